// File: doc/BRIEF.md
# Power-Good Strap Capture and Clock Mode Decoder

This block sits beside the reset logic of a clock generator. When the system power-good strobe is first seen low, it starts a power-up sequence. The strobe is active low and level sensitive, and it is synchronised into the reference clock domain first. The block then waits a programmable settling delay and captures the frequency-select and current-multiplier straps exactly once. Next it turns the VCO on, and after a VCO settling window it turns the clock outputs on. Later activity on the strobe or on the straps has no effect until the block is reset.

The captured straps are decoded into four results:
- a two-bit CPU frequency code;
- an operating mode: internal VCO, buffered from an external 66 MHz input, high-impedance, or test divide-down;
- an error flag for reserved strap codes;
- a divide ratio for each output group (CPU, 66 MHz group, PCI, reference, USB/DOT).

The top select strap is a three-level pin. The analog front end delivers it already encoded as a 2-bit level code. The raw latched straps are also presented as a read-only status word.

Top module: `pwrgood_strap_top`

## Requirements
- R1: After reset, `state` is 0, `vco_en`, `outs_en`, `captured` and `err_reserved` are 0, `strap_status` is 0, `mode` is 2 (high-impedance) and every divide ratio is 0.
- R2: `state` encodes the sequence as follows: 0 waiting, 1 delay, 2 sample, 3 VCO start, 4 outputs on. The low level of `pg_n` passes through SYNC_STAGES flip-flops. The first cycle it is seen low, the next edge moves state 0 to 1. State 1 lasts DELAY_TICKS cycles and state 2 lasts one cycle.
- R3: On the edge that leaves state 2, the straps are latched and `captured` rises. `strap_status` then holds bits [4:3] = `sel_top`, bits [2:1] = `sel_low` and bit [0] = `mult_strap`.
- R4: After capture, changes on `pg_n`, `sel_top`, `sel_low` or `mult_strap` do not alter `state`, `strap_status` or any decoded output until reset.
- R5: State 3 lasts VCO_TICKS cycles and is then followed by state 4, which is held. `vco_en` is 1 in states 3 and 4. `outs_en` is 1 only in state 4 and only when `mode` is not 2.
- R6: The level code of `sel_top` is 00 low, 01 mid, 10 high and 11 invalid. With `sel_top` = 10, `mode` is 1 (buffered) and `cpu_code` equals `sel_low`, with 00 = 66, 01 = 100, 10 = 200 and 11 = 133 MHz. The ratios are then CPU 1, 66 MHz group 1, PCI 2, reference 1, USB 1.
- R7: With `sel_top` = 00, `mode` is 0 (internal VCO), and `cpu_code` and the ratios are as in R6.
- R8: With `sel_top` = 01 and `sel_low` = 00, `mode` is 2, `cpu_code` is 0, every ratio is 0 and `err_reserved` is 0.
- R9: With `sel_top` = 01 and `sel_low` = 01, `mode` is 3 (test), `cpu_code` is 10 (the 200 MHz dividers) and the ratios from the test clock are CPU 2, 66 MHz group 4, PCI 8, reference 1, USB 2.
- R10: With `sel_top` = 01 and `sel_low` = 10 or 11, or with `sel_top` = 11, `mode` is 2, every ratio is 0, `cpu_code` is 0 and `err_reserved` is 1.
- R11: Before capture, the decoded outputs are held at the values given in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pg_n | input | 1 | Power-good strobe, active low, asynchronous |
| sel_top | input | 2 | Encoded three-level top select (00 low, 01 mid, 10 high) |
| sel_low | input | 2 | Low frequency selects |
| mult_strap | input | 1 | Current-multiplier strap |
| state | output | 3 | Power-up sequence state |
| vco_en | output | 1 | VCO enable |
| outs_en | output | 1 | Clock output enable |
| captured | output | 1 | Straps have been latched |
| strap_status | output | 5 | Latched straps {top, low, mult} |
| mode | output | 2 | Operating mode code |
| cpu_code | output | 2 | CPU frequency code |
| err_reserved | output | 1 | Reserved strap code captured |
| div_cpu | output | DIV_W | CPU group divide ratio |
| div_grp66 | output | DIV_W | 66 MHz group divide ratio |
| div_pci | output | DIV_W | PCI group divide ratio |
| div_ref | output | DIV_W | Reference output divide ratio |
| div_usb | output | DIV_W | USB/DOT divide ratio |

## Verification
The bench builds the block with SYNC_STAGES = 2, DELAY_TICKS = 5 and VCO_TICKS = 3. These short windows bring the whole sequence, from strobe to outputs on, within a few tens of cycles. Every strap combination, including both reserved forms, can therefore run from a fresh reset. After each capture, the bench toggles the strobe and flips every strap. This shows that the latched values and the sequence stay frozen.

// File: rtl/strap_pkg.sv
// Shared types for the power-good strap capture block.
// Assumes the top select arrives already resolved into a 2-bit level code.
package strap_pkg;
    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_DELAY  = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_VCO    = 3'd3,
        ST_ON     = 3'd4
    } pwr_state_t;

    typedef enum logic [1:0] {
        MD_INTERNAL = 2'd0,
        MD_BUFFERED = 2'd1,
        MD_HIZ      = 2'd2,
        MD_TEST     = 2'd3
    } clk_mode_t;

    localparam logic [1:0] LVL_LOW  = 2'b00;
    localparam logic [1:0] LVL_MID  = 2'b01;
    localparam logic [1:0] LVL_HIGH = 2'b10;

    typedef struct packed {
        logic [1:0] top;
        logic [1:0] low;
        logic       mult;
    } strap_t;

    localparam int STRAP_W = $bits(strap_t);
endpackage

// File: rtl/pg_sync.sv
// Synchronises the asynchronous active-low power-good strobe.
// Assumes STAGES >= 2; the chain resets to the inactive (high) level.
module pg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pg_n,
    output logic pg_seen
);
    logic [STAGES-1:0] chain;

    // first stage samples the raw strobe
    always_ff @(posedge clk) begin
        if (!rst_n) chain[0] <= 1'b1;
        else        chain[0] <= pg_n;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // each later stage re-times the previous one
            always_ff @(posedge clk) begin
                if (!rst_n) chain[g] <= 1'b1;
                else        chain[g] <= chain[g-1];
            end
        end
    endgenerate

    assign pg_seen = ~chain[STAGES-1];
endmodule

// File: rtl/powerup_fsm.sv
// Power-up sequencer: wait for power good, settle, sample, start VCO, enable.
// Assumes DELAY_TICKS and VCO_TICKS are at least 1; the final state holds until reset.
module powerup_fsm
    import strap_pkg::*;
#(
    parameter int DELAY_TICKS = 3580,
    parameter int VCO_TICKS   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pg_seen,
    output pwr_state_t state,
    output logic       sample_pulse,
    output logic       vco_en
);
    localparam int MAX_TICKS = (DELAY_TICKS > VCO_TICKS) ? DELAY_TICKS : VCO_TICKS;
    localparam int CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] DLY_LAST = CNT_W'(DELAY_TICKS - 1);
    localparam logic [CNT_W-1:0] VCO_LAST = CNT_W'(VCO_TICKS - 1);

    pwr_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next-state and window counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_WAIT: begin
                if (pg_seen) begin
                    state_d = ST_DELAY;
                    cnt_d   = '0;
                end
            end
            ST_DELAY: begin
                if (cnt_q == DLY_LAST) begin
                    state_d = ST_SAMPLE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_SAMPLE: begin
                state_d = ST_VCO;
                cnt_d   = '0;
            end
            ST_VCO: begin
                if (cnt_q == VCO_LAST) begin
                    state_d = ST_ON;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_ON:   state_d = ST_ON;
            default: state_d = ST_WAIT;
        endcase
    end

    // state and counter registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign state        = state_q;
    assign sample_pulse = (state_q == ST_SAMPLE);
    assign vco_en       = (state_q == ST_VCO) || (state_q == ST_ON);
endmodule

// File: rtl/strap_latch.sv
// One-shot strap capture register.
// Assumes the straps are stable during the sample state; reset is the only way to re-arm.
module strap_latch
    import strap_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   sample_pulse,
    input  strap_t straps_in,
    output strap_t straps_q,
    output logic   captured
);
    // capture once, then hold
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            straps_q <= '0;
            captured <= 1'b0;
        end else if (sample_pulse && !captured) begin
            straps_q <= straps_in;
            captured <= 1'b1;
        end
    end
endmodule

// File: rtl/mode_decode.sv
// Decodes the latched straps into mode, CPU code, error flag and group ratios.
// Assumes the inputs come from registers; the outputs read as high-impedance until capture.
module mode_decode
    import strap_pkg::*;
#(
    parameter int DIV_W = 4
) (
    input  strap_t     straps,
    input  logic       captured,
    output clk_mode_t  mode,
    output logic [1:0] cpu_code,
    output logic       err_reserved,
    output logic [DIV_W-1:0] div_cpu,
    output logic [DIV_W-1:0] div_grp66,
    output logic [DIV_W-1:0] div_pci,
    output logic [DIV_W-1:0] div_ref,
    output logic [DIV_W-1:0] div_usb
);
    localparam int NGRP = 5;
    // ratio per group, index order: cpu, grp66, pci, ref, usb
    localparam int RUN_RATIO  [NGRP] = '{1, 1, 2, 1, 1};
    localparam int TEST_RATIO [NGRP] = '{2, 4, 8, 1, 2};

    logic [DIV_W-1:0] ratio [NGRP];

    // mode, CPU code and reserved-code classification
    always_comb begin
        mode         = MD_HIZ;
        cpu_code     = 2'b00;
        err_reserved = 1'b0;
        if (captured) begin
            unique case (straps.top)
                LVL_LOW: begin
                    mode     = MD_INTERNAL;
                    cpu_code = straps.low;
                end
                LVL_HIGH: begin
                    mode     = MD_BUFFERED;
                    cpu_code = straps.low;
                end
                LVL_MID: begin
                    if (straps.low == 2'b01) begin
                        mode     = MD_TEST;
                        cpu_code = 2'b10;
                    end else if (straps.low != 2'b00) begin
                        err_reserved = 1'b1;
                    end
                end
                default: err_reserved = 1'b1;
            endcase
        end
    end

    genvar g;
    generate
        for (g = 0; g < NGRP; g++) begin : g_ratio
            // ratio of one output group for the decoded mode
            always_comb begin
                unique case (mode)
                    MD_TEST:                  ratio[g] = DIV_W'(TEST_RATIO[g]);
                    MD_INTERNAL, MD_BUFFERED: ratio[g] = DIV_W'(RUN_RATIO[g]);
                    default:                  ratio[g] = '0;
                endcase
            end
        end
    endgenerate

    assign div_cpu   = ratio[0];
    assign div_grp66 = ratio[1];
    assign div_pci   = ratio[2];
    assign div_ref   = ratio[3];
    assign div_usb   = ratio[4];
endmodule

// File: rtl/pwrgood_strap_top.sv
// Top of the power-good strap capture and clock mode decoder.
// Assumes straps are settled by the end of the delay window and that pg_n is asynchronous.
module pwrgood_strap_top
    import strap_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DELAY_TICKS = 3580,
    parameter int VCO_TICKS   = 256,
    parameter int DIV_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pg_n,
    input  logic [1:0]       sel_top,
    input  logic [1:0]       sel_low,
    input  logic             mult_strap,
    output logic [2:0]       state,
    output logic             vco_en,
    output logic             outs_en,
    output logic             captured,
    output logic [4:0]       strap_status,
    output logic [1:0]       mode,
    output logic [1:0]       cpu_code,
    output logic             err_reserved,
    output logic [DIV_W-1:0] div_cpu,
    output logic [DIV_W-1:0] div_grp66,
    output logic [DIV_W-1:0] div_pci,
    output logic [DIV_W-1:0] div_ref,
    output logic [DIV_W-1:0] div_usb
);
    logic       pg_seen;
    logic       sample_pulse;
    pwr_state_t st;
    strap_t     straps_raw, straps_q;
    clk_mode_t  mode_e;

    assign straps_raw = '{top: sel_top, low: sel_low, mult: mult_strap};

    pg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pg_n(pg_n), .pg_seen(pg_seen)
    );

    powerup_fsm #(.DELAY_TICKS(DELAY_TICKS), .VCO_TICKS(VCO_TICKS)) u_fsm (
        .clk(clk), .rst_n(rst_n), .pg_seen(pg_seen),
        .state(st), .sample_pulse(sample_pulse), .vco_en(vco_en)
    );

    strap_latch u_latch (
        .clk(clk), .rst_n(rst_n), .sample_pulse(sample_pulse),
        .straps_in(straps_raw), .straps_q(straps_q), .captured(captured)
    );

    mode_decode #(.DIV_W(DIV_W)) u_dec (
        .straps(straps_q), .captured(captured), .mode(mode_e),
        .cpu_code(cpu_code), .err_reserved(err_reserved),
        .div_cpu(div_cpu), .div_grp66(div_grp66), .div_pci(div_pci),
        .div_ref(div_ref), .div_usb(div_usb)
    );

    // port-level views of the internal enums and the output gate
    always_comb begin
        state        = st;
        mode         = mode_e;
        strap_status = straps_q;
        outs_en      = (st == ST_ON) && (mode_e != MD_HIZ);
    end
endmodule

// File: rtl/pwrgood_strap_chk.sv
// Temporal checks for pwrgood_strap_top, attached through bind.
// Assumes the state and mode encodings given in the requirements.
module pwrgood_strap_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] state,
    input logic       vco_en,
    input logic       outs_en,
    input logic       captured,
    input logic [4:0] strap_status,
    input logic [1:0] mode,
    input logic       err_reserved
);
    AST_STATUS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        captured |=> $stable(strap_status) && captured); // R4
    AST_CAPTURE_FROM_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(captured) |-> $past(state) == 3'd2); // R3
    AST_STATE_STEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (state != $past(state)) |-> (state == $past(state) + 3'd1)); // R2
    AST_OUTS_NEED_VCO: assert property (@(posedge clk) disable iff (!rst_n)
        outs_en |-> vco_en && mode != 2'd2); // R5
    AST_ERR_IS_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        err_reserved |-> mode == 2'd2); // R10
    AST_PRECAPTURE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        !captured |-> mode == 2'd2 && !err_reserved); // R11
endmodule

bind pwrgood_strap_top pwrgood_strap_chk chk_i (
    .clk(clk), .rst_n(rst_n), .state(state), .vco_en(vco_en),
    .outs_en(outs_en), .captured(captured), .strap_status(strap_status),
    .mode(mode), .err_reserved(err_reserved)
);

// File: tb/pwrgood_strap_top_tb_top.sv
module pwrgood_strap_top_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SYNC = 2;
    localparam int DLY  = 5;
    localparam int VCOT = 3;
    localparam int DW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pg_n = 1'b1;
    logic [1:0] sel_top = 2'b00, sel_low = 2'b00;
    logic mult_strap = 1'b0;
    logic [2:0] state;
    logic vco_en, outs_en, captured, err_reserved;
    logic [4:0] strap_status;
    logic [1:0] mode, cpu_code;
    logic [DW-1:0] div_cpu, div_grp66, div_pci, div_ref, div_usb;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit started = 0;

    pwrgood_strap_top #(.SYNC_STAGES(SYNC), .DELAY_TICKS(DLY), .VCO_TICKS(VCOT), .DIV_W(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pg_n(pg_n), .sel_top(sel_top), .sel_low(sel_low),
        .mult_strap(mult_strap), .state(state), .vco_en(vco_en), .outs_en(outs_en),
        .captured(captured), .strap_status(strap_status), .mode(mode), .cpu_code(cpu_code),
        .err_reserved(err_reserved), .div_cpu(div_cpu), .div_grp66(div_grp66),
        .div_pci(div_pci), .div_ref(div_ref), .div_usb(div_usb)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // behavioural reference model
    bit pgq[$];
    int m_state = 0, m_cnt = 0;
    bit m_cap = 0;
    bit [4:0] m_lat = 0;

    always @(posedge clk) begin
        started = 1;
        cycles++;
        if (!rst_n) begin
            pgq = {};
            for (int i = 0; i < SYNC; i++) pgq.push_back(1'b1);
            m_state = 0; m_cnt = 0; m_cap = 0; m_lat = 0;
        end else begin
            bit seen;
            seen = (pgq[0] == 1'b0);
            case (m_state)
                0: if (seen) begin m_state = 1; m_cnt = 0; end
                1: if (m_cnt == DLY - 1) begin m_state = 2; m_cnt = 0; end else m_cnt++;
                2: begin m_lat = {sel_top, sel_low, mult_strap}; m_cap = 1; m_state = 3; m_cnt = 0; end
                3: if (m_cnt == VCOT - 1) begin m_state = 4; m_cnt = 0; end else m_cnt++;
                default: m_state = 4;
            endcase
            void'(pgq.pop_front());
            pgq.push_back(pg_n);
        end
    end

    task automatic check(string req, string what, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // expected decode from the requirements
    task automatic expect_dec(output int md, output int cc, output int er, output int d[5], output string tag);
        bit [1:0] t, l;
        t = m_lat[4:3]; l = m_lat[2:1];
        md = 2; cc = 0; er = 0; d = '{0, 0, 0, 0, 0}; tag = "R11";
        if (m_cap) begin
            if (t == 2'b10)      begin md = 1; cc = l; d = '{1, 1, 2, 1, 1}; tag = "R6"; end
            else if (t == 2'b00) begin md = 0; cc = l; d = '{1, 1, 2, 1, 1}; tag = "R7"; end
            else if (t == 2'b01 && l == 2'b00) tag = "R8";
            else if (t == 2'b01 && l == 2'b01) begin md = 3; cc = 2; d = '{2, 4, 8, 1, 2}; tag = "R9"; end
            else begin er = 1; tag = "R10"; end
        end
    endtask

    // compare every cycle away from the active edge
    always @(negedge clk) begin
        if (started) begin
            int md, cc, er;
            int d[5];
            string tag;
            expect_dec(md, cc, er, d, tag);
            check("R2", "state", state, m_state);
            check("R5", "vco_en", vco_en, (m_state >= 3));
            check("R5", "outs_en", outs_en, (m_state == 4 && md != 2));
            check("R3", "captured", captured, m_cap);
            check("R3", "strap_status", strap_status, m_lat);
            check(tag, "mode", mode, md);
            check(tag, "cpu_code", cpu_code, cc);
            check(tag, "err_reserved", err_reserved, er);
            check(tag, "div_cpu", div_cpu, d[0]);
            check(tag, "div_grp66", div_grp66, d[1]);
            check(tag, "div_pci", div_pci, d[2]);
            check(tag, "div_ref", div_ref, d[3]);
            check(tag, "div_usb", div_usb, d[4]);
        end
    end

    task automatic run_case(bit [1:0] t, bit [1:0] l, bit m);
        @(negedge clk);
        rst_n = 1'b0; pg_n = 1'b1;
        sel_top = t; sel_low = l; mult_strap = m;
        repeat (2) @(negedge clk);
        check("R1", "reset state", state, 0);
        check("R1", "reset status", strap_status, 0);
        check("R1", "reset mode", mode, 2);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R2", "waits without power good", state, 0);
        pg_n = 1'b0;
        repeat (SYNC + DLY + 1 + VCOT + 4) @(negedge clk);
        check("R5", "reached outputs-on", state, 4);
        check("R3", "latched straps", strap_status, {t, l, m});
        // disturb every input after capture
        pg_n = 1'b1; sel_top = ~t; sel_low = ~l; mult_strap = ~m;
        repeat (3) @(negedge clk);
        pg_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R4", "status after disturbance", strap_status, {t, l, m});
        check("R4", "state after disturbance", state, 4);
    endtask

    // watchdog
    initial begin
        #(CLK_PERIOD * 20000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        run_case(2'b10, 2'b00, 1'b0); // R6 66
        run_case(2'b10, 2'b11, 1'b1); // R6 133
        run_case(2'b00, 2'b01, 1'b0); // R7 100
        run_case(2'b00, 2'b10, 1'b1); // R7 200
        run_case(2'b01, 2'b00, 1'b1); // R8
        run_case(2'b01, 2'b01, 1'b0); // R9
        run_case(2'b01, 2'b10, 1'b0); // R10
        run_case(2'b01, 2'b11, 1'b1); // R10
        run_case(2'b11, 2'b00, 1'b0); // R10 invalid level
        // a single-cycle low pulse still starts the sequence (level seen once)
        @(negedge clk); rst_n = 1'b0; pg_n = 1'b1; sel_top = 2'b10; sel_low = 2'b01;
        repeat (2) @(negedge clk); rst_n = 1'b1;
        @(negedge clk); pg_n = 1'b0;
        @(negedge clk); pg_n = 1'b1;
        repeat (SYNC + DLY + VCOT + 5) @(negedge clk);
        check("R2", "short pulse sequence", state, 4);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule